// File: doc/BRIEF.md
# RS(15,11) Systematic Encoder with Bit-Serial Parity Datapath

This block turns eleven 4-bit information symbols into a fifteen-symbol systematic Reed-Solomon codeword over GF(16), with the field built on x^4 + x + 1. The parity is the remainder of the message times x^4 divided by a degree-4 generator. That remainder is kept in four symbol-wide registers, and the feedback shift runs through them. The four multipliers have fixed operands and work one bit at a time. Each therefore spends four clock cycles on every information symbol, with the feedback symbol fed in most significant bit first and the partial products folded in by XOR.

A start pulse while the block is idle opens a codeword. One clearing cycle follows, and the block then takes symbols on a valid/ready input stream. Every accepted symbol is passed unchanged to a registered valid/ready output. After the eleventh symbol, the four parity symbols leave on the same output. Back-pressure rules: the output holds its symbol stable while `out_valid` is high and `out_ready` is low. The input raises `in_ready` only when the datapath is waiting for a new symbol and the output register is free in that cycle. A source may hold `in_valid` low for any number of cycles, and this only delays the codeword.

Top module: `rs15_enc`

## Requirements
- R1: After reset, `busy`, `in_ready` and `out_valid` are all low.
- R2: A `start` pulse while `busy` is low raises `busy` on the next cycle. That cycle clears the parity registers and accepts no input. The first symbol can be taken on the second clock edge after the edge that samples `start`.
- R3: Each accepted symbol occupies the datapath for 4 cycles. `in_ready` stays low for the 3 cycles after an acceptance.
- R4: Each accepted information symbol appears unchanged on `out_data`, with `out_valid` high, in the cycle after it is accepted. Symbols leave in arrival order.
- R5: The four symbols that follow the 11 information symbols are the coefficients of x^3, x^2, x^1 and x^0, in that order, of (m(x)·x^4) mod g(x). Here the first information symbol is the coefficient of x^14, g(x) = (x+α)(x+α^2)(x+α^3)(x+α^4), α = 4'b0010, and bit 3 of a symbol is the x^3 coordinate.
- R6: The 15 output symbols of every codeword, read as a polynomial whose first symbol is the highest coefficient, evaluate to zero at α, α^2, α^3 and α^4.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. No symbol is dropped or repeated.
- R8: A `start` pulse while `busy` is high has no effect on the codeword in progress.
- R9: With `in_valid` and `out_ready` held high, encoding takes 45 cycles: one clearing cycle plus 44 bit cycles. The first parity symbol is valid after the 46th clock edge that follows the edge sampling `start`.
- R10: Idle cycles on `in_valid` between symbols do not change the codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a codeword when idle |
| in_valid | input | 1 | Information symbol present |
| in_ready | output | 1 | Encoder takes the symbol this cycle |
| in_data | input | 4 | Information symbol |
| out_valid | output | 1 | Codeword symbol present |
| out_ready | input | 1 | Downstream takes the symbol this cycle |
| out_data | output | 4 | Codeword symbol, information first, then parity |
| busy | output | 1 | A codeword is in progress |

## Verification
The scoreboard checks parity against a long-division model, and every codeword's four syndromes must come out zero. A wrong generator coefficient, a bit-order slip in a serial multiplier, or a reversed parity order would show up as mismatches and nonzero syndromes. Runs with random output back-pressure and input gaps expose a design that drops or repeats a symbol, or that moves on while stalled. A start pulse during encoding would corrupt the output if it were not ignored. In an unstalled run, cycle counts are measured from start to the first acceptance, between acceptances, and to the first parity symbol. This catches a missing clearing cycle or a wrong number of bit cycles.

// File: rtl/rs15_enc_pkg.sv
package rs15_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } enc_state_e;

  // GF(2^w) product, field polynomial given with its x^w term
  function automatic logic [15:0] gf_prod(logic [15:0] a, logic [15:0] b,
                                          int unsigned poly, int unsigned w);
    logic [15:0] acc;
    logic [15:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(w)) begin
        if (b[i]) acc = acc ^ sh;
        sh = sh << 1;
        if (sh[w]) sh = sh ^ 16'(poly);
      end
    end
    return acc;
  endfunction

  // Coefficient idx of prod_{k} (x + alpha^(first+k)), k = 0..npar-1
  function automatic logic [15:0] gen_coef(int unsigned idx, int unsigned npar,
                                           int unsigned first, int unsigned poly,
                                           int unsigned w);
    logic [15:0] g [16];
    logic [15:0] root;
    for (int j = 0; j < 16; j++) g[j] = '0;
    g[0] = 16'd1;
    root = 16'd1;
    for (int k = 0; k < 16; k++)
      if (k < int'(first)) root = gf_prod(root, 16'd2, poly, w);
    for (int i = 0; i < 15; i++) begin
      if (i < int'(npar)) begin
        for (int j = 15; j > 0; j--)
          if (j <= i + 1) g[j] = g[j-1] ^ gf_prod(g[j], root, poly, w);
        g[0] = gf_prod(g[0], root, poly, w);
        root = gf_prod(root, 16'd2, poly, w);
      end
    end
    return g[idx];
  endfunction

endpackage

// File: rtl/rs15_smul.sv
// Bit-serial multiply by a fixed coefficient; operand bits arrive MSB first.
module rs15_smul #(
  parameter int unsigned W    = 4,
  parameter int unsigned POLY = 19,
  parameter logic [W-1:0] COEF = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         step,
  input  logic         bit_in,
  output logic [W-1:0] prod_nxt
);
  localparam logic [W-1:0] RED = W'(POLY);

  logic [W-1:0] acc_q;
  logic [W-1:0] doubled;

  assign doubled  = {acc_q[W-2:0], 1'b0} ^ (acc_q[W-1] ? RED : '0);
  assign prod_nxt = (load ? '0 : doubled) ^ (bit_in ? COEF : '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   acc_q <= '0;
    else if (load || step) acc_q <= prod_nxt;
  end
endmodule

// File: rtl/rs15_seq.sv
module rs15_seq #(
  parameter int unsigned SYM_W  = 4,
  parameter int unsigned N_INFO = 11,
  parameter int unsigned N_PAR  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic accept,
  input  logic out_free,
  output logic slot,
  output logic step,
  output logic last_bit,
  output logic clr,
  output logic drain_go,
  output logic busy
);
  import rs15_enc_pkg::*;

  localparam int unsigned BW = (SYM_W > 2) ? $clog2(SYM_W) : 1;
  localparam int unsigned SW = $clog2(N_INFO + 1);
  localparam int unsigned PW = $clog2(N_PAR + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(SYM_W - 1);
  localparam logic [SW-1:0] SYM_LAST = SW'(N_INFO - 1);
  localparam logic [PW-1:0] PAR_LAST = PW'(N_PAR - 1);

  enc_state_e    st_q;
  logic [BW-1:0] bit_q;
  logic [SW-1:0] sym_q;
  logic [PW-1:0] par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sym_q <= '0;
      par_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start) st_q <= ST_CLEAR;
        ST_CLEAR: begin
          bit_q <= '0;
          sym_q <= '0;
          par_q <= '0;
          st_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (bit_q == '0) begin
            if (accept) bit_q <= BW'(1);
          end else if (bit_q == BIT_LAST) begin
            bit_q <= '0;
            if (sym_q == SYM_LAST) begin
              sym_q <= '0;
              st_q  <= ST_DRAIN;
            end else begin
              sym_q <= sym_q + SW'(1);
            end
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
        ST_DRAIN: if (out_free) begin
          if (par_q == PAR_LAST) begin
            par_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            par_q <= par_q + PW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clr      = (st_q == ST_CLEAR);
  assign slot     = (st_q == ST_RUN) && (bit_q == '0);
  assign step     = (st_q == ST_RUN) && (bit_q != '0);
  assign last_bit = (st_q == ST_RUN) && (bit_q == BIT_LAST);
  assign drain_go = (st_q == ST_DRAIN) && out_free;
  assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/rs15_enc.sv
module rs15_enc #(
  parameter int unsigned SYM_W      = 4,
  parameter int unsigned N_INFO     = 11,
  parameter int unsigned N_PAR      = 4,
  parameter int unsigned POLY       = 19,
  parameter int unsigned FIRST_ROOT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             busy
);
  logic slot, step, last_bit, clr, drain_go, out_free, accept;
  logic [N_PAR-1:0][SYM_W-1:0] par_q;
  logic [N_PAR-1:0][SYM_W-1:0] prod;
  logic [SYM_W-1:0] fb_now, fb_q;
  logic             fb_bit;

  assign out_free = !out_valid || out_ready;
  assign in_ready = slot && out_free;
  assign accept   = in_valid && in_ready;
  assign fb_now   = in_data ^ par_q[N_PAR-1];
  assign fb_bit   = accept ? fb_now[SYM_W-1] : fb_q[SYM_W-1];

  rs15_seq #(.SYM_W(SYM_W), .N_INFO(N_INFO), .N_PAR(N_PAR)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .out_free(out_free), .slot(slot), .step(step), .last_bit(last_bit),
    .clr(clr), .drain_go(drain_go), .busy(busy)
  );

  for (genvar i = 0; i < int'(N_PAR); i++) begin : g_tap
    localparam logic [SYM_W-1:0] TAP =
      SYM_W'(rs15_enc_pkg::gen_coef(i, N_PAR, FIRST_ROOT, POLY, SYM_W));
    rs15_smul #(.W(SYM_W), .POLY(POLY), .COEF(TAP)) u_mul (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(accept), .step(step),
      .bit_in(fb_bit), .prod_nxt(prod[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fb_q <= '0;
    else if (accept) fb_q <= fb_now << 1;
    else if (step)   fb_q <= fb_q << 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) par_q <= '0;
    else if (last_bit) par_q <= (par_q << SYM_W) ^ prod;
    else if (drain_go) par_q <= par_q << SYM_W;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (drain_go) begin
      out_valid <= 1'b1;
      out_data  <= par_q[N_PAR-1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rs15_enc_chk.sv
module rs15_enc_chk #(
  parameter int unsigned SYM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SYM_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] out_data,
  input logic             busy
);
  assert_idle_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !in_ready));

  assert_symbol_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  assert_out_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind rs15_enc rs15_enc_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/rs15_enc_tb.sv
module rs15_enc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_data;
  logic       busy;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int t_start  = 0;
  int t_par    = 0;
  int t_acc [11];
  bit bp_mode  = 1'b0;
  bit done     = 1'b0;

  logic [3:0] exp_q [$];
  logic [3:0] msg [11];
  logic [3:0] gh [5];
  logic [3:0] cw [15];
  int         cw_n = 0;

  rs15_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] fmul(logic [3:0] a, logic [3:0] b);
    logic [3:0] r = '0;
    for (int i = 3; i >= 0; i--) begin
      r = {r[2:0], 1'b0} ^ (r[3] ? 4'h3 : 4'h0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // generator, highest coefficient first
  task automatic build_gen();
    logic [3:0] gl [5];
    logic [3:0] r;
    gl[0] = 4'd1;
    for (int j = 1; j < 5; j++) gl[j] = 4'd0;
    r = 4'd2;
    for (int k = 0; k < 4; k++) begin
      for (int j = 4; j > 0; j--) gl[j] = gl[j-1] ^ fmul(gl[j], r);
      gl[0] = fmul(gl[0], r);
      r = fmul(r, 4'd2);
    end
    for (int k = 0; k < 5; k++) gh[k] = gl[4-k];
  endtask

  // long division model: push full expected codeword
  task automatic push_expected();
    logic [3:0] w [15];
    for (int i = 0; i < 15; i++) w[i] = (i < 11) ? msg[i] : 4'd0;
    for (int i = 0; i < 11; i++) begin
      logic [3:0] q;
      q = w[i];
      for (int j = 0; j < 5; j++) w[i+j] = w[i+j] ^ fmul(q, gh[j]);
    end
    for (int i = 0; i < 11; i++) exp_q.push_back(msg[i]);
    for (int i = 11; i < 15; i++) exp_q.push_back(w[i]);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected output symbol", int'(out_data), -1);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(out_data == e, (cw_n < 11) ? "R4 info symbol" : "R5 parity symbol",
              int'(out_data), int'(e));
      end
      if (cw_n == 11) t_par = cyc;
      cw[cw_n] = out_data;
      cw_n++;
      if (cw_n == 15) begin
        logic [3:0] a;
        a = 4'd2;
        for (int j = 1; j <= 4; j++) begin
          logic [3:0] s;
          s = '0;
          for (int i = 0; i < 15; i++) s = fmul(s, a) ^ cw[i];
          check(s == 4'd0, "R6 syndrome", int'(s), 0);
          a = fmul(a, 4'd2);
        end
        cw_n = 0;
      end
    end
  end

  // output back-pressure driver
  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic send(logic [3:0] sym, int gap, output int t_a);
    for (int g = 0; g < gap; g++) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = sym;
    while (1) begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    t_a = cyc;
    in_valid = 1'b0;
  endtask

  task automatic encode(int gap, bit mid_start, bit timed);
    push_expected();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    t_start = cyc;
    if (timed) begin
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      check(in_ready == 1'b0, "R2 clearing cycle takes no input", int'(in_ready), 0);
    end
    for (int i = 0; i < 11; i++) begin
      int ta;
      if (mid_start && i == 5) start = 1'b1;
      send(msg[i], gap, ta);
      start = 1'b0;
      t_acc[i] = ta;
    end
    wait (exp_q.size() == 0 && !busy);
    @(negedge clk);
    if (timed) begin
      check(t_acc[0] - t_start == 2, "R2 first acceptance edge", t_acc[0] - t_start, 2);
      for (int i = 1; i < 11; i++)
        check(t_acc[i] - t_acc[i-1] == 4, "R3 symbol spacing",
              t_acc[i] - t_acc[i-1], 4);
      check(t_par - t_start == 46, "R9 first parity edge", t_par - t_start, 46);
    end
    check(cw_n == 0, "R7 codeword length", cw_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    build_gen();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R3 / R5: unstalled counting message
    for (int i = 0; i < 11; i++) msg[i] = 4'(i + 1);
    encode(0, 1'b0, 1'b1);

    // R5: all-zero message gives zero parity
    for (int i = 0; i < 11; i++) msg[i] = 4'd0;
    encode(0, 1'b0, 1'b0);

    // R5: single unit in the last symbol gives generator low coefficients
    for (int i = 0; i < 11; i++) msg[i] = (i == 10) ? 4'd1 : 4'd0;
    encode(0, 1'b0, 1'b1);

    // R5: all ones
    for (int i = 0; i < 11; i++) msg[i] = 4'hF;
    encode(0, 1'b0, 1'b0);

    // R7 / R10: random data under back-pressure and input gaps
    bp_mode = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 11; i++) msg[i] = 4'($urandom);
      encode(r, 1'b0, 1'b0);
    end

    // R8: start pulse in the middle of a codeword
    for (int i = 0; i < 11; i++) msg[i] = 4'($urandom);
    encode(1, 1'b1, 1'b0);
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R8 no extra codeword after start while busy", int'(busy), 0);
    check(out_valid == 1'b0, "R8 output quiet afterwards", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule